// File: doc/BRIEF.md
# Edge Change-Detection Interrupt Unit

This block watches a bundle of 8-bit digital input ports. When an enabled line has a rising or falling edge, the block records the event in a sticky flag and can raise a single interrupt request. Each port has two enable masks, one for rising edges and one for falling edges. A global control register picks which edge directions are counted and which flags may drive the interrupt. It also holds a master gate for the interrupt.

Software uses a byte-wide register interface with an address, a write strobe, write data and combinational read data. It programs the masks and the control register, then waits for the interrupt. It reads the status register to see which flags are set, and writes the clear register to acknowledge them. If a second enabled edge arrives before the first one is acknowledged, an overflow flag is set, so lost events can be detected. The inputs are asynchronous to the clock and pass through a two-stage synchronizer first.

Top module: `edge_irq_unit`

## Requirements
- R1: Reset clears every mask, the control register and both flags. After reset, `irq` is 0 and the status, control and mask registers read 0x00.
- R2: A read at address 0x00 returns the identification byte given by parameter `ID_VALUE` (default 0xC5). Writes to that address have no effect.
- R3: For port n, below `NPORT`, the rising-edge mask is at 0x42 + 0x10·n and the falling-edge mask is at 0x43 + 0x10·n. Both are read/write, and each bit enables the line of the same index. The control register at 0x03 keeps bits 4:0 and reads 0 in bits 7:5. Unmapped addresses, and mask addresses of ports at or above `NPORT`, read 0x00 and ignore writes. The status register ignores writes. A register changes only when it is written.
- R4: A rising edge is counted when three things hold: the line's rising mask bit is set, control bit 3 is set, and the line goes 0→1. A counted rising edge sets the edge flag, which is status bit 0. The flag becomes visible after the third rising clock edge that follows the input change, and not after the second.
- R5: A falling edge is counted when three things hold: the line's falling mask bit is set, control bit 4 is set, and the line goes 1→0. A counted falling edge sets the edge flag with the same latency as in R4.
- R6: An edge does not change the flags in either of two cases: the line's mask bit for that direction is clear, or the direction enable for that edge (control bit 3 for rising, bit 4 for falling) is clear.
- R7: A counted edge that arrives while the edge flag is already set, and is not being cleared in that cycle, sets the overflow flag, which is status bit 1.
- R8: A write to the clear register at 0x01 has these effects. With bit 3 set, it clears the edge flag. With bit 2 set, it clears the overflow flag. Its other bits have no effect. A counted edge in the same cycle leaves the edge flag set.
- R9: `irq` is master enable (control bit 2) AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)). Status bit 2 reads back `irq`.
- R10: Writing 0x00 to the control register deasserts `irq` from the next cycle. After that write, no edge sets a flag. Flags that are already set stay set until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| port_in | input | 8·NPORT | Asynchronous input lines, port n in bits 8n+7:8n |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four rules on every cycle. The edge flag rises only after a detector hit. Overflow rises only when a hit meets a flag that is already set. A clear write with no competing hit drops the edge flag, and a zero write to the control register silences `irq`. They also check that masks hold between writes, and that no hit is produced when both direction enables are off. Only the bench scenarios can show the rest: the exact three-cycle detection latency, the mapping of the per-port mask addresses to their lines, the separate behaviour of the rising and falling paths, and the routing of each flag to the interrupt through its own enable.

// File: rtl/edet_pkg.sv
package edet_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_ID     = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_CLR    = 8'h01;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 8'h02;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 8'h03;
  localparam int                MASK_BASE  = 'h40;
  localparam int                MASK_STEP  = 'h10;
  localparam int                RISE_OFS   = 2;
  localparam int                FALL_OFS   = 3;

  localparam int CLR_EDGE_BIT = 3;
  localparam int CLR_OVF_BIT  = 2;
  localparam int CTRL_W       = 5;

  // bit 4 .. bit 0
  typedef struct packed {
    logic fall_en;
    logic rise_en;
    logic master_en;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;

  function automatic logic [ADDR_W-1:0] mask_addr(input int port, input logic falling);
    return ADDR_W'(MASK_BASE + port * MASK_STEP + (falling ? FALL_OFS : RISE_OFS));
  endfunction
endpackage

// File: rtl/edet_sync.sv
module edet_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, stab_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign cur  = stab_q;
  assign prev = prev_q;
endmodule

// File: rtl/edet_detect.sv
module edet_detect #(
  parameter int NPORT = 4,
  parameter int PW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT*PW-1:0]        cur,
  input  logic [NPORT*PW-1:0]        prev,
  input  logic [NPORT-1:0][PW-1:0]   rise_mask,
  input  logic [NPORT-1:0][PW-1:0]   fall_mask,
  input  logic                       rise_en,
  input  logic                       fall_en,
  output logic                       hit
);
  logic [NPORT-1:0] port_hit;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PW-1:0] up, down;
    always_comb begin
      up   = cur[p*PW +: PW] & ~prev[p*PW +: PW] & rise_mask[p];
      down = ~cur[p*PW +: PW] & prev[p*PW +: PW] & fall_mask[p];
      port_hit[p] = (rise_en & (|up)) | (fall_en & (|down));
    end
  end

  assign hit = |port_hit;

  AST_DIR_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_en && !fall_en) |-> !hit); // R6
endmodule

// File: rtl/edet_regs.sv
module edet_regs
  import edet_pkg::*;
#(
  parameter int                NPORT    = 4,
  parameter logic [DATA_W-1:0] ID_VALUE = 8'hC5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         wr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  input  logic                         hit,
  output logic [NPORT-1:0][DATA_W-1:0] rise_mask,
  output logic [NPORT-1:0][DATA_W-1:0] fall_mask,
  output logic                         rise_en,
  output logic                         fall_en,
  output logic                         irq
);
  ctrl_t ctrl_q, ctrl_d;
  logic  edge_q, edge_d, ovf_q, ovf_d;
  logic  clr_edge, clr_ovf, ctrl_we;
  logic [NPORT-1:0][DATA_W-1:0] rmask_q, fmask_q;

  // Per-port enable masks
  for (genvar p = 0; p < NPORT; p++) begin : g_mask
    localparam logic [ADDR_W-1:0] RADR = mask_addr(p, 1'b0);
    localparam logic [ADDR_W-1:0] FADR = mask_addr(p, 1'b1);
    logic          r_we, f_we;
    logic [DATA_W-1:0] r_d, f_d;

    always_comb begin
      r_we = wr && (addr == RADR);
      f_we = wr && (addr == FADR);
      r_d  = r_we ? wdata : rmask_q[p];
      f_d  = f_we ? wdata : fmask_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rmask_q[p] <= '0;
        fmask_q[p] <= '0;
      end else begin
        rmask_q[p] <= r_d;
        fmask_q[p] <= f_d;
      end
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(rmask_q[p]) && $stable(fmask_q[p]))); // R3
  end

  // Control and sticky flags: next state
  always_comb begin
    ctrl_we  = wr && (addr == ADR_CTRL);
    clr_edge = wr && (addr == ADR_CLR) && wdata[CLR_EDGE_BIT];
    clr_ovf  = wr && (addr == ADR_CLR) && wdata[CLR_OVF_BIT];
    ctrl_d   = ctrl_we ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
    edge_d   = hit | (edge_q & ~clr_edge);
    ovf_d    = (ovf_q & ~clr_ovf) | (hit & edge_q & ~clr_edge);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      edge_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      edge_q <= edge_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    irq = ctrl_q.master_en & ((edge_q & ctrl_q.edge_ie) | (ovf_q & ctrl_q.ovf_ie));
  end

  // Read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_ID:   rdata = ID_VALUE;
      ADR_STAT: rdata = {{(DATA_W-3){1'b0}}, irq, ovf_q, edge_q};
      ADR_CTRL: rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      default: begin
        for (int p = 0; p < NPORT; p++) begin
          if (addr == mask_addr(p, 1'b0)) rdata = rmask_q[p];
          if (addr == mask_addr(p, 1'b1)) rdata = fmask_q[p];
        end
      end
    endcase
  end

  assign rise_mask = rmask_q;
  assign fall_mask = fmask_q;
  assign rise_en   = ctrl_q.rise_en;
  assign fall_en   = ctrl_q.fall_en;

  AST_EDGE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_q) |-> $past(hit)); // R4
  AST_OVF_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(hit && edge_q)); // R7
  AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_CLR && wdata[CLR_EDGE_BIT] && !hit) |=> !edge_q); // R8
  AST_CTRL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_CTRL && wdata == '0) |=> !irq); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (edge_q || ovf_q)); // R9
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edet_pkg::*;
#(
  parameter int                NPORT    = 4,
  parameter logic [DATA_W-1:0] ID_VALUE = 8'hC5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic [NPORT*DATA_W-1:0] port_in,
  output logic                    irq
);
  localparam int PW    = DATA_W;
  localparam int LINES = NPORT * PW;

  logic [LINES-1:0]             cur, prev;
  logic [NPORT-1:0][PW-1:0]     rise_mask, fall_mask;
  logic                         rise_en, fall_en, hit;

  edet_sync #(.W(LINES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (port_in),
    .cur (cur),
    .prev (prev)
  );

  edet_detect #(.NPORT(NPORT), .PW(PW)) u_detect (
    .clk (clk),
    .rst_n (rst_n),
    .cur (cur),
    .prev (prev),
    .rise_mask (rise_mask),
    .fall_mask (fall_mask),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .hit (hit)
  );

  edet_regs #(.NPORT(NPORT), .ID_VALUE(ID_VALUE)) u_regs (
    .clk (clk),
    .rst_n (rst_n),
    .addr (reg_addr),
    .wr (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .hit (hit),
    .rise_mask (rise_mask),
    .fall_mask (fall_mask),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .irq (irq)
  );
endmodule

// File: tb/tb_edge_irq_unit.sv
module tb_edge_irq_unit;
  localparam int NPORT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr, wdata, rdata;
  logic        wr;
  logic [NPORT*8-1:0] pins;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_irq_unit #(.NPORT(NPORT), .ID_VALUE(8'hC5)) dut (
    .clk (clk), .rst_n (rst_n), .reg_addr (addr), .reg_wr (wr),
    .reg_wdata (wdata), .reg_rdata (rdata), .port_in (pins), .irq (irq)
  );

  // {address, write data, expected readback}
  localparam logic [23:0] VEC [8] = '{
    {8'h42, 8'h5A, 8'h5A},
    {8'h73, 8'h81, 8'h81},
    {8'h62, 8'h0F, 8'h0F},
    {8'h03, 8'hFF, 8'h1F},
    {8'h00, 8'h33, 8'hC5},
    {8'h44, 8'hFF, 8'h00},
    {8'h82, 8'hFF, 8'h00},
    {8'h02, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    addr = a; wr = 1'b0;
    #1;
    d = rdata;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pins[idx] = v;
  endtask

  task automatic settle3();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; pins = '0;
    do_reset();

    // Register table: write, then read back
    for (int i = 0; i < 8; i++) begin
      wr_reg(VEC[i][23:16], VEC[i][15:8]);
      rd_reg(VEC[i][23:16], v);
      chk((VEC[i][23:16] == 8'h00) ? "R2 id" : "R3 regmap", v, VEC[i][7:0]);
    end

    // R1: reset state
    do_reset();
    rd_reg(8'h02, v); chk("R1 status", v, 8'h00);
    rd_reg(8'h03, v); chk("R1 ctrl", v, 8'h00);
    rd_reg(8'h42, v); chk("R1 mask", v, 8'h00);
    rd_reg(8'h73, v); chk("R1 mask", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R4: rising edge on port1 line2, latency
    wr_reg(8'h52, 8'h04);
    wr_reg(8'h03, 8'h0D);
    set_pin(10, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd_reg(8'h02, v); chk("R4 not yet", v, 8'h00);
    @(posedge clk); @(negedge clk);
    rd_reg(8'h02, v); chk("R4 edge", v, 8'h05);
    chk("R9 irq edge", {7'd0, irq}, 8'h01);

    // R6 falling not enabled; R7 overflow
    set_pin(10, 1'b0); settle3();
    rd_reg(8'h02, v); chk("R6 fall off", v, 8'h05);
    set_pin(10, 1'b1); settle3();
    rd_reg(8'h02, v); chk("R7 overflow", v, 8'h07);

    // R8 clears
    wr_reg(8'h01, 8'h08);
    rd_reg(8'h02, v); chk("R8 clr edge", v, 8'h02);
    chk("R9 ovf ie off", {7'd0, irq}, 8'h00);
    wr_reg(8'h01, 8'h04);
    rd_reg(8'h02, v); chk("R8 clr ovf", v, 8'h00);

    // R5 falling on port3 line7
    wr_reg(8'h73, 8'h80);
    wr_reg(8'h03, 8'h17);
    set_pin(31, 1'b1); settle3();
    rd_reg(8'h02, v); chk("R6 rise off", v, 8'h00);
    set_pin(31, 1'b0); settle3();
    rd_reg(8'h02, v); chk("R5 fall", v, 8'h05);
    chk("R5 irq", {7'd0, irq}, 8'h01);

    // R8 other clear bits ignored
    wr_reg(8'h01, 8'hF3);
    rd_reg(8'h02, v); chk("R8 other bits", v, 8'h05);

    // R6 masked line
    wr_reg(8'h01, 8'h0C);
    wr_reg(8'h03, 8'h1F);
    set_pin(0, 1'b1); settle3();
    set_pin(0, 1'b0); settle3();
    rd_reg(8'h02, v); chk("R6 masked line", v, 8'h00);

    // R9 overflow-only interrupt
    wr_reg(8'h03, 8'h0E);
    set_pin(10, 1'b0); settle3();
    set_pin(10, 1'b1); settle3();
    rd_reg(8'h02, v); chk("R9 edge no ie", v, 8'h01);
    chk("R9 irq off", {7'd0, irq}, 8'h00);
    set_pin(10, 1'b0); settle3();
    set_pin(10, 1'b1); settle3();
    rd_reg(8'h02, v); chk("R9 ovf irq", v, 8'h07);
    chk("R9 irq on", {7'd0, irq}, 8'h01);

    // R10 control off
    wr_reg(8'h03, 8'h00);
    chk("R10 irq off", {7'd0, irq}, 8'h00);
    rd_reg(8'h02, v); chk("R10 flags kept", v, 8'h03);
    wr_reg(8'h01, 8'h0C);
    set_pin(10, 1'b0); settle3();
    set_pin(10, 1'b1); settle3();
    rd_reg(8'h02, v); chk("R10 no record", v, 8'h00);

    // R1: reset mid-run
    do_reset();
    rd_reg(8'h52, v); chk("R1 mask after reset", v, 8'h00);
    rd_reg(8'h02, v); chk("R1 status after reset", v, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule